// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

A single timer channel behind a small word-addressed register port. Software programs a reload value and a control byte; once enabled, the channel decrements a counter on every prescaled tick and raises a raw interrupt flag each time the count runs out. The counter can be 16 or 32 bits wide. The prescaler divides the clock by 1, 16 or 256.

Three counting modes are available. In free-running mode the counter restarts from the all-ones value of its width. In periodic mode it restarts from the stored reload value. In one-shot mode it halts at zero after its first expiry. The reload value can be written in two ways. The immediate path also restarts the count. The background path only changes what the next reload will use. The interrupt pin is the raw flag gated by an enable bit, and a write-only clear register drops the flag.

Register word offsets (byte address, low two bits zero): 0x00 reload (immediate), 0x04 current count (read only), 0x08 control, 0x0C flag clear (write only), 0x10 raw flag, 0x14 masked flag, 0x18 reload (background).

Top module: `dtimer_channel`

## Requirements
- R1: After reset the control byte reads 0x20, the raw flag, current count and reload value read 0, and irqOut is low.
- R2: Control byte: bit 0 one-shot, bit 1 wide (32-bit) counter, bits 3:2 prescale (00 and 11 = /1, 01 = /16, 10 = /256), bit 5 interrupt enable, bit 6 periodic, bit 7 enable. A write at 0x08 stores bits 7:0, and a read at 0x08 returns them zero-extended.
- R3: A write at 0x00 stores the value and, in the same clock edge, loads the counter from the reload source of the current mode.
- R4: A write at 0x18 stores the value without changing the count. Reads at 0x00 and 0x18 both return the stored value, and the next reload uses it.
- R5: While enabled, the count drops by one on each prescaled tick. Ticks come every 1, 16 or 256 clocks after the enabling control write.
- R6: Expiry is a tick with count 1, or a tick with count 0 outside one-shot mode. It sets the raw flag, read at 0x10 in bit 0. In periodic mode the counter reloads from the stored value, so the period is that value in ticks.
- R7: With periodic and one-shot both clear, the reload source is 0xFFFF (16-bit) or 0xFFFFFFFF (32-bit). In 16-bit mode only the low 16 bits count, and the count reads with the upper half zero. A periodic reload in 16-bit mode uses the low half of the stored value.
- R8: In one-shot mode the counter stops at 0 after its first expiry and stays there.
- R9: Any write at 0x0C clears the raw flag. An expiry in the same cycle wins.
- R10: irqOut is high exactly when the raw flag and the interrupt-enable bit are both set. A read at 0x14 returns that same value in bit 0.
- R11: Writes at 0x04, at unmapped offsets (0x1C and up) and at addresses with nonzero low bits change nothing. Reads there, and at 0x0C, return 0.
- R12: A control write with enable set reloads the counter from the new mode's source and restarts the prescaler. A control write with enable clear leaves the count as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWrite | input | 1 | Write strobe; reads are combinational when low |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr |
| irqOut | output | 1 | Masked interrupt request |

## Verification
The bench keeps a reference model of the register and counter state and compares it against every read and against irqOut on every cycle. Random traffic mixes mode changes, immediate and background reloads, clears and writes to ignored offsets. Small reload values keep expiries frequent, so the periodic reload, the one-shot halt and free-running wrap are told apart by the count sequences they produce. Directed cases pin down the exact /16 tick spacing and the all-ones reload in both widths. They also cover the one-shot park at zero, raw versus masked flag with the enable bit off, and a clear against a held flag.

// File: rtl/dtimer_pkg.sv
`timescale 1ns/1ps
package dtimer_pkg;

  // Strobes from the control side to the counting datapath
  typedef struct packed {
    logic reloadNow;   // load counter from reloadVal this edge
    logic tick;        // one prescaled count step
    logic clrFlag;     // software clear of the raw flag
  } tmrStrobe_t;

  // Word index of each register (byte offset >> 2)
  localparam int IDX_LOAD   = 0;
  localparam int IDX_VALUE  = 1;
  localparam int IDX_CTRL   = 2;
  localparam int IDX_CLEAR  = 3;
  localparam int IDX_RAW    = 4;
  localparam int IDX_MASKED = 5;
  localparam int IDX_BGLOAD = 6;

  // Control byte bit positions
  localparam int BIT_ONESHOT  = 0;
  localparam int BIT_WIDE     = 1;
  localparam int BIT_DIV_LO   = 2;
  localparam int BIT_IE       = 5;
  localparam int BIT_PERIODIC = 6;
  localparam int BIT_EN       = 7;

  localparam logic [7:0] CTRL_RESET = 8'h20;

endpackage

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl
  import dtimer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] countIn,
  input  logic              rawFlag,
  output tmrStrobe_t        strobe,
  output logic [DATA_W-1:0] reloadVal,
  output logic [DATA_W-1:0] periodVal,
  output logic              oneShot,
  output logic              wide,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);

  localparam int IDX_W  = ADDR_W - 2;
  localparam int HALF_W = DATA_W / 2;
  localparam logic [PRE_W-1:0] LIM_DIV16  = PRE_W'(15);
  localparam logic [PRE_W-1:0] LIM_DIV256 = PRE_W'(255);
  localparam logic [DATA_W-1:0] HALF_ONES = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

  logic [7:0]        ctrlReg;
  logic [DATA_W-1:0] loadReg;
  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W-1:0]  preLimit;
  logic [IDX_W-1:0]  wordIdx;
  logic              aligned;
  logic              loadWr, bgWr, ctlWr, clrWr;
  logic              preHit;
  logic [7:0]        ctlNext;
  logic [DATA_W-1:0] srcLoad;

  function automatic logic [DATA_W-1:0] fillValue(input logic [7:0] c,
                                                  input logic [DATA_W-1:0] ld);
    logic freeRun;
    freeRun = !c[BIT_PERIODIC] && !c[BIT_ONESHOT];
    if (freeRun) fillValue = c[BIT_WIDE] ? '1 : HALF_ONES;
    else         fillValue = c[BIT_WIDE] ? ld : (ld & HALF_ONES);
  endfunction

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    loadWr = busWrite && aligned && (wordIdx == IDX_W'(IDX_LOAD));
    bgWr   = busWrite && aligned && (wordIdx == IDX_W'(IDX_BGLOAD));
    ctlWr  = busWrite && aligned && (wordIdx == IDX_W'(IDX_CTRL));
    clrWr  = busWrite && aligned && (wordIdx == IDX_W'(IDX_CLEAR));
  end

  // Prescale limit selected by control bits 3:2
  always_comb begin
    case (ctrlReg[BIT_DIV_LO +: 2])
      2'b01:   preLimit = LIM_DIV16;
      2'b10:   preLimit = LIM_DIV256;
      default: preLimit = '0;
    endcase
  end

  assign preHit = (preCnt == preLimit);

  always_comb begin
    ctlNext          = ctlWr  ? busWdata[7:0] : ctrlReg;
    srcLoad          = loadWr ? busWdata      : loadReg;
    strobe.reloadNow = loadWr || (ctlWr && busWdata[BIT_EN]);
    strobe.tick      = ctrlReg[BIT_EN] && preHit && !ctlWr;
    strobe.clrFlag   = clrWr;
    reloadVal        = fillValue(ctlNext, srcLoad);
    periodVal        = fillValue(ctrlReg, loadReg);
    oneShot          = ctrlReg[BIT_ONESHOT];
    wide             = ctrlReg[BIT_WIDE];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RESET;
      loadReg <= '0;
      preCnt  <= '0;
    end else begin
      if (ctlWr) ctrlReg <= busWdata[7:0];
      if (loadWr || bgWr) loadReg <= busWdata;
      if (ctlWr || !ctrlReg[BIT_EN] || preHit) preCnt <= '0;
      else preCnt <= preCnt + 1'b1;
    end
  end

  assign irqOut = rawFlag && ctrlReg[BIT_IE];

  // Read mux
  always_comb begin
    busRdata = '0;
    if (aligned) begin
      case (wordIdx)
        IDX_W'(IDX_LOAD), IDX_W'(IDX_BGLOAD): busRdata = loadReg;
        IDX_W'(IDX_VALUE):  busRdata = countIn;
        IDX_W'(IDX_CTRL):   busRdata = DATA_W'(ctrlReg);
        IDX_W'(IDX_RAW):    busRdata = DATA_W'(rawFlag);
        IDX_W'(IDX_MASKED): busRdata = DATA_W'(irqOut);
        default:            busRdata = '0;
      endcase
    end
  end

  AST_DIV16_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && ctrlReg[BIT_DIV_LO +: 2] == 2'b01) |=> !strobe.tick); // R5

  AST_VALUE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ADDR_W'(4)) |=> ($stable(loadReg) && $stable(ctrlReg))); // R11

endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
module tmr_count
  import dtimer_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic [DATA_W-1:0] reloadVal,
  input  logic [DATA_W-1:0] periodVal,
  input  logic              oneShot,
  input  logic              wide,
  output logic [DATA_W-1:0] countOut,
  output logic              rawFlag
);

  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] HALF_MASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] cntMasked;
  logic              atOne, atZero, expire;

  assign cntMasked = wide ? count : (count & HALF_MASK);
  assign atOne     = (cntMasked == ONE);
  assign atZero    = (cntMasked == '0);
  assign expire    = strobe.tick && (atOne || (atZero && !oneShot));
  assign countOut  = cntMasked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      rawFlag <= 1'b0;
    end else begin
      if (strobe.reloadNow)                count <= reloadVal;
      else if (expire)                     count <= oneShot ? '0 : periodVal;
      else if (strobe.tick && !atZero)     count <= cntMasked - ONE;

      if (expire)              rawFlag <= 1'b1;
      else if (strobe.clrFlag) rawFlag <= 1'b0;
    end
  end

  AST_RELOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reloadNow |=> (count == $past(reloadVal))); // R3

  AST_EXPIRY_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && cntMasked == ONE) |=> rawFlag); // R6

  AST_ONESHOT_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    (oneShot && cntMasked == '0 && !strobe.reloadNow) |=> (countOut == '0)); // R8

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrFlag && !strobe.tick) |=> !rawFlag); // R9

endmodule

// File: rtl/dtimer_channel.sv
`timescale 1ns/1ps
module dtimer_channel
  import dtimer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);

  tmrStrobe_t        strobe;
  logic [DATA_W-1:0] reloadVal, periodVal, countVal;
  logic              oneShot, wide, rawFlag;

  tmr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrite(busWrite), .busWdata(busWdata),
    .countIn(countVal), .rawFlag(rawFlag),
    .strobe(strobe), .reloadVal(reloadVal), .periodVal(periodVal),
    .oneShot(oneShot), .wide(wide),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  tmr_count #(.DATA_W(DATA_W)) uCount (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .reloadVal(reloadVal), .periodVal(periodVal),
    .oneShot(oneShot), .wide(wide),
    .countOut(countVal), .rawFlag(rawFlag)
  );

  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ADDR_W'(12) && !strobe.tick) |=> !irqOut); // R10

endmodule

// File: tb/dtimer_channel_test.sv
`timescale 1ns/1ps
module dtimer_channel_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state
  logic [31:0] mLoad;
  logic [7:0]  mCtrl;
  logic [31:0] mCnt;
  logic [7:0]  mPre;
  logic        mFlag;

  always #5 clk = ~clk;

  dtimer_channel uut (
    .clk(clk), .rstN(rstN), .busAddr(addr), .busWrite(wr),
    .busWdata(wdata), .busRdata(rdata), .irqOut(irq)
  );

  function automatic logic [31:0] fill(input logic [7:0] c, input logic [31:0] ld);
    if (!c[6] && !c[0]) return c[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    return c[1] ? ld : {16'h0, ld[15:0]};
  endfunction

  function automatic logic [7:0] preLim(input logic [7:0] c);
    case (c[3:2])
      2'b01:   return 8'd15;
      2'b10:   return 8'd255;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [31:0] cntView(input logic [7:0] c, input logic [31:0] v);
    return c[1] ? v : {16'h0, v[15:0]};
  endfunction

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[7:2])
      6'd0, 6'd6: return mLoad;
      6'd1:       return cntView(mCtrl, mCnt);
      6'd2:       return {24'h0, mCtrl};
      6'd4:       return {31'h0, mFlag};
      6'd5:       return {31'h0, mFlag & mCtrl[5]};
      default:    return 32'h0;
    endcase
  endfunction

  function automatic string tagFor(input logic [7:0] a);
    if (a[1:0] != 2'b00) return "R11";
    case (a[7:2])
      6'd0, 6'd6: return "R4";
      6'd1:       return "R5";
      6'd2:       return "R2";
      6'd4:       return "R6";
      6'd5:       return "R10";
      default:    return "R11";
    endcase
  endfunction

  // Reference model steps on the same edge as the design
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLoad = '0; mCtrl = 8'h20; mCnt = '0; mPre = '0; mFlag = 1'b0;
    end else begin
      logic al, loadWr, ctlWr, bgWr, clr, tick, os, ex;
      logic [31:0] cm, nc;
      logic [7:0]  nCtrl;
      al     = (addr[1:0] == 2'b00);
      loadWr = wr && al && addr[7:2] == 6'd0;
      ctlWr  = wr && al && addr[7:2] == 6'd2;
      clr    = wr && al && addr[7:2] == 6'd3;
      bgWr   = wr && al && addr[7:2] == 6'd6;
      tick   = mCtrl[7] && mPre == preLim(mCtrl) && !ctlWr;
      cm     = cntView(mCtrl, mCnt);
      os     = mCtrl[0];
      ex     = tick && (cm == 32'd1 || (cm == 32'd0 && !os));
      nCtrl  = ctlWr ? wdata[7:0] : mCtrl;
      if (loadWr || (ctlWr && wdata[7])) nc = fill(nCtrl, loadWr ? wdata : mLoad);
      else if (ex)                       nc = os ? 32'h0 : fill(mCtrl, mLoad);
      else if (tick && cm != 0)          nc = cm - 1;
      else                               nc = mCnt;
      if (ctlWr || !mCtrl[7] || mPre == preLim(mCtrl)) mPre = '0;
      else mPre = mPre + 1;
      if (ex) mFlag = 1'b1; else if (clr) mFlag = 1'b0;
      if (loadWr || bgWr) mLoad = wdata;
      mCtrl = nCtrl;
      mCnt  = nc;
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One bus cycle: drive at the falling edge, check outputs 1 ns later
  task automatic busCycle(input logic [7:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr = w; wdata = d;
    #1;
    if (!w) check(tagFor(a), "read vs model", rdata, modelRead(a));
    check("R10", "irqOut vs model", {31'h0, irq}, {31'h0, mFlag & mCtrl[5]});
  endtask

  task automatic rd(input logic [7:0] a);
    busCycle(a, 1'b0, 32'h0);
  endtask

  task automatic wrt(input logic [7:0] a, input logic [31:0] d);
    busCycle(a, 1'b1, d);
  endtask

  // Read with an expected value fixed by the requirements
  task automatic rdExp(input string tag, input logic [7:0] a, input logic [31:0] exp);
    busCycle(a, 1'b0, 32'h0);
    check(tag, "directed read", rdata, exp);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED);
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    rdExp("R1", 8'h08, 32'h20);
    rdExp("R1", 8'h10, 32'h0);
    rdExp("R1", 8'h04, 32'h0);
    rdExp("R1", 8'h00, 32'h0);
    check("R1", "irq at reset", {31'h0, irq}, 32'h0);

    // R7 free-running reload values, both widths
    wrt(8'h08, 32'h20);
    wrt(8'h00, 32'h1234);
    rdExp("R7", 8'h04, 32'h0000_FFFF);
    rdExp("R4", 8'h18, 32'h1234);
    wrt(8'h08, 32'h22);
    wrt(8'h00, 32'h55);
    rdExp("R7", 8'h04, 32'hFFFF_FFFF);

    // R12 / R5 enable reloads, /16 spacing
    wrt(8'h00, 32'd3);
    wrt(8'h08, 32'hE6);              // en, periodic, ie, /16, wide
    for (int k = 0; k <= 16; k++)
      rdExp("R5", 8'h04, (k < 16) ? 32'd3 : 32'd2);

    // R12 disable holds count
    wrt(8'h08, 32'h62);
    repeat (5) rd(8'h04);
    rdExp("R12", 8'h04, 32'd2);

    // R8 one-shot stop
    wrt(8'h00, 32'd4);
    wrt(8'h08, 32'hA3);              // en, ie, wide, one-shot
    repeat (12) rd(8'h04);
    rdExp("R8", 8'h04, 32'd0);
    rdExp("R6", 8'h10, 32'd1);
    check("R10", "irq after one-shot expiry", {31'h0, irq}, 32'd1);

    // R10 masked vs raw with enable bit off
    wrt(8'h08, 32'h03);
    rdExp("R10", 8'h14, 32'd0);
    rdExp("R10", 8'h10, 32'd1);
    check("R10", "irq masked off", {31'h0, irq}, 32'd0);

    // R9 clear
    wrt(8'h0C, 32'h0);
    rdExp("R9", 8'h10, 32'd0);

    // R11 ignored writes
    wrt(8'h04, 32'hDEAD_BEEF);
    rdExp("R11", 8'h04, 32'd0);
    wrt(8'h1C, 32'hFFFF_FFFF);
    wrt(8'h01, 32'hFFFF_FFFF);
    rdExp("R11", 8'h1C, 32'd0);
    rdExp("R11", 8'h00, 32'd4);
    rdExp("R11", 8'h08, 32'h03);

    // R4 background load during periodic run
    wrt(8'h00, 32'd10);
    wrt(8'h08, 32'hE2);
    rd(8'h04); rd(8'h04);
    wrt(8'h18, 32'd3);
    repeat (25) rd(8'h04);
    rdExp("R4", 8'h00, 32'd3);

    // Random traffic against the model
    for (int i = 0; i < 2500; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: wrt(8'h00, ($urandom_range(0, 7) == 0) ? $urandom : 32'($urandom_range(0, 30)));
        1: wrt(8'h18, 32'($urandom_range(0, 30)));
        2: begin
             logic [7:0] c;
             c = 8'($urandom) & 8'hE3;
             if ($urandom_range(0, 5) == 0) c[3:2] = 2'($urandom);
             if ($urandom_range(0, 3) != 0) c[7] = 1'b1;
             wrt(8'h08, {24'($urandom), c});
           end
        3: wrt(8'h0C, $urandom);
        4: wrt(8'($urandom_range(0, 63)), $urandom);
        default: rd(8'($urandom_range(0, 7) * 4));
      endcase
    end

    @(negedge clk);
    wr = 1'b0;
    finish();
  end

endmodule